// File: doc/BRIEF.md
# Clock-Generator Control Register File over I2C

This block is a two-wire serial slave that holds the 8-bit control registers of a clock generator. Every register drives a parallel output bus that the clock-control logic decodes. These registers set output enables, spread mode, skew, software frequency selection and a global output-tristate bit. A write transfer has no sub-address. After the device address, the master sends two header bytes whose contents do not matter. Every data byte after the headers goes to the next register, starting from register 0.

A read transfer returns the same sequence, starting at register 0. After the writable registers the slave returns two fixed identification bytes, and after those it returns 0xFF. SCL and SDA pass through a synchronizer into the system clock domain, which must run at least eight times faster than SCL. SDA is open-drain: the slave only ever pulls it low, through an output enable. Only the power-up reset restores the register contents. No bus event restores them.

Top module: `clkctl_i2c_regs`

## Requirements
- R1: After power-up reset the register outputs hold these values: register 1, register 2 and register 3 hold 0xFF. Register 5 holds 0x93 (skew fields 100 and 100 in bits 7:5 and 4:2, clock enables in bits 1:0 set). Registers 0, 4 and 6 to 10 hold 0x00. Register n appears on regs_o[8n+7:8n].
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged. Any other address is not acknowledged, and the bytes that follow it change no register until the next START.
- R3: In a write, the first two bytes after the address are acknowledged, and their values reach no register.
- R4: Each data byte after the two header bytes is acknowledged and lands in the next register, starting at register 0. A register changes only in the cycle after such a byte completes.
- R5: Data bytes beyond register NUM_WR-1 (register 10 by default) are acknowledged and discarded. Nothing is written at the two identification positions or beyond them.
- R6: In a read (address LSB = 1), the slave returns register 0 first and then each following register in order, as long as the master acknowledges. After the writable registers it returns 0x50, then 0x42, then 0xFF. A master NACK ends the read.
- R7: A STOP or a repeated START at any bit position ends the transfer. A partly received byte is discarded, and registers already written keep their new values.
- R8: The slave starts pulling SDA low only while SCL is low, and it leaves SDA released outside its acknowledge and read-data slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low power-up reset, the only reset of register contents |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | NUM_WR*8 | All writable registers; register n in bits 8n+7:8n |

## Verification
The hardest cases to reach are transfers cut short in the middle. These are a STOP or repeated START after only a few bits of a data byte, and a write long enough to run past the writable registers into the identification positions. The bench drives the bus one bit at a time, so it can stop a byte after any number of bits and choose the transfer length freely. Random write and read transfers, with random lengths and header contents, are mixed with these directed cuts. A bench model of the registers predicts every read-back byte.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } link_st_t;

   // power-up value of each writable register
   function automatic logic [7:0] reg_default(input int idx);
      case (idx)
         1, 2, 3: reg_default = 8'hFF;
         5:       reg_default = 8'h93;
         default: reg_default = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/clkctl_i2c_sync.sv
module clkctl_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_q, sda_q;
   logic scl_p, sda_p, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s    = scl_q[STAGES-1];
   assign sda_s    = sda_q[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
   import clkctl_pkg::*;
#(
   parameter int           NUM_WR = 11,
   parameter int           PTR_W  = 4,
   parameter logic [7:0]   ID_HI  = 8'h50,
   parameter logic [7:0]   ID_LO  = 8'h42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [7:0]        wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [7:0]        rdata,
   output logic [NUM_WR*8-1:0] regs_o
);
   localparam logic [PTR_W-1:0] ID_HI_POS = PTR_W'(NUM_WR);
   localparam logic [PTR_W-1:0] ID_LO_POS = PTR_W'(NUM_WR + 1);

   logic [7:0] q [NUM_WR];

   generate
      for (genvar i = 0; i < NUM_WR; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= reg_default(i);
            else if (we && waddr == PTR_W'(i))
               q[i] <= wdata;
         end
         assign regs_o[8*i +: 8] = q[i];
      end
   endgenerate

   always_comb begin
      rdata = 8'hFF;
      if (raddr == ID_HI_POS)
         rdata = ID_HI;
      else if (raddr == ID_LO_POS)
         rdata = ID_LO;
      for (int i = 0; i < NUM_WR; i++)
         if (raddr == PTR_W'(i))
            rdata = q[i];
   end
endmodule

// File: rtl/clkctl_i2c_link.sv
module clkctl_i2c_link
   import clkctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NUM_WR   = 11,
   parameter int         PTR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [7:0]        rdata,
   output logic              sda_oe,
   output logic              we,
   output logic [PTR_W-1:0]  waddr,
   output logic [7:0]        wdata,
   output logic [PTR_W-1:0]  ptr
);
   localparam logic [PTR_W-1:0] WR_END  = PTR_W'(NUM_WR);
   localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_WR + 2);

   link_st_t   st;
   logic [7:0] shreg, txreg;
   logic [3:0] bitcnt;
   logic [1:0] hdr;
   logic       rnw, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; shreg <= '0; txreg <= '0; bitcnt <= '0;
         hdr <= '0; rnw <= 1'b0; mack <= 1'b0; ptr <= '0;
         sda_oe <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
      end else begin
         we <= 1'b0;
         if (start_ev) begin
            st <= ST_ADDR; bitcnt <= '0; ptr <= '0; hdr <= '0; sda_oe <= 1'b0;
         end else if (stop_ev) begin
            st <= ST_IDLE; sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (st == ST_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1; rnw <= shreg[0]; st <= ST_ADDR_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        sda_oe <= 1'b1; st <= ST_RX_ACK;
                        if (hdr != 2'd2) begin
                           hdr <= hdr + 2'd1;
                        end else begin
                           if (ptr < WR_END) begin
                              we <= 1'b1; waddr <= ptr; wdata <= shreg;
                           end
                           if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                        end
                     end
                  end
               end
               ST_ADDR_ACK, ST_RX_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (st == ST_ADDR_ACK && rnw) begin
                        txreg <= rdata; sda_oe <= ~rdata[7]; st <= ST_TX;
                        if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                     end else begin
                        sda_oe <= 1'b0; st <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0; st <= ST_TX_ACK;
                     end else begin
                        bitcnt <= bitcnt + 4'd1;
                        txreg  <= {txreg[6:0], 1'b0};
                        sda_oe <= ~txreg[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        txreg <= rdata; sda_oe <= ~rdata[7]; st <= ST_TX; bitcnt <= '0;
                        if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/clkctl_i2c_regs.sv
module clkctl_i2c_regs #(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_WR      = 11,
   parameter logic [7:0] ID_HI       = 8'h50,
   parameter logic [7:0] ID_LO       = 8'h42,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_oe,
   output logic [NUM_WR*8-1:0] regs_o
);
   localparam int PTR_W = $clog2(NUM_WR + 3);

   generate
      if (NUM_WR < 6 || NUM_WR > 250) begin : g_bad_num
         $error("NUM_WR must lie in 6..250");
      end
   endgenerate

   logic             sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic             wr_en;
   logic [PTR_W-1:0] wr_addr, rd_ptr;
   logic [7:0]       wr_data, rd_data;

   clkctl_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   clkctl_i2c_link #(.DEV_ADDR(DEV_ADDR), .NUM_WR(NUM_WR), .PTR_W(PTR_W)) u_link (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
      .rdata(rd_data), .sda_oe(sda_oe), .we(wr_en), .waddr(wr_addr),
      .wdata(wr_data), .ptr(rd_ptr)
   );

   clkctl_regbank #(.NUM_WR(NUM_WR), .PTR_W(PTR_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
      .raddr(rd_ptr), .rdata(rd_data), .regs_o(regs_o)
   );
endmodule

// File: rtl/clkctl_i2c_regs_chk.sv
module clkctl_i2c_regs_chk #(
   parameter int NUM_WR = 11,
   parameter int PTR_W  = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_i,
   input logic                sda_oe,
   input logic                stop_ev,
   input logic                wr_en,
   input logic [PTR_W-1:0]    wr_addr,
   input logic [NUM_WR*8-1:0] regs_o
);
   // R8: pull-down begins only during SCL low
   p_drive_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   // R5: no write strobe outside the writable range
   p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr < PTR_W'(NUM_WR)));

   // R4: registers move only after a write strobe
   p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o));

   // R4: every stored byte is acknowledged
   p_ack_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sda_oe);

   // R7: a STOP releases the line
   p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);
endmodule

bind clkctl_i2c_regs clkctl_i2c_regs_chk #(.NUM_WR(NUM_WR), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .stop_ev(stop_ev),
   .wr_en(wr_en), .wr_addr(wr_addr), .regs_o(regs_o)
);

// File: tb/test_clkctl_i2c_regs.sv
module test_clkctl_i2c_regs;
   localparam int NW = 11;
   localparam logic [6:0] DEV = 7'h69;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe;
   logic [NW*8-1:0] regs_o;
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0, fails = 0;
   logic [7:0] exp_r [NW];
   logic [7:0] wb [16];

   always #4 clk = ~clk;

   clkctl_i2c_regs i_clkctl_i2c_regs (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .regs_o(regs_o)
   );

   function automatic logic [7:0] dflt(input int i);
      if (i >= 1 && i <= 3) return 8'hFF;
      if (i == 5) return 8'h93;
      return 8'h00;
   endfunction

   function automatic logic [7:0] exp_rd(input int i);
      if (i < NW) return exp_r[i];
      if (i == NW) return 8'h50;
      if (i == NW + 1) return 8'h42;
      return 8'hFF;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic wq; repeat (4) @(negedge clk); endtask

   task automatic i2c_start;
      sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0;
   endtask

   task automatic i2c_stop;
      wq; sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
   endtask

   task automatic bit_x(input logic b, output logic s);
      wq; sda_m = b; wq; scl_m = 1'b1; wq; s = sda_line; wq; scl_m = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_x(d[i], s);
      bit_x(1'b1, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); d[i] = s; end
      bit_x(~mack, s);
   endtask

   task automatic check_regs(input string req);
      for (int i = 0; i < NW; i++)
         chk(regs_o[8*i +: 8] == exp_r[i], req, regs_o[8*i +: 8], exp_r[i]);
   endtask

   // write transfer: n data bytes from wb[]; model updated when addressed
   task automatic wr_xact(input logic [6:0] a, input int n, input logic [7:0] h0, input logic [7:0] h1);
      logic ack;
      i2c_start;
      wr_byte({a, 1'b0}, ack);
      chk(ack == (a == DEV), "R2 address ack", ack, a == DEV);
      wr_byte(h0, ack);
      if (a == DEV) chk(ack, "R3 header ack", ack, 1);
      wr_byte(h1, ack);
      if (a == DEV) chk(ack, "R3 header ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         wr_byte(wb[i], ack);
         if (a == DEV) begin
            chk(ack, (i >= NW) ? "R5 ack past end" : "R4 data ack", ack, 1);
            if (i < NW) exp_r[i] = wb[i];
         end
      end
      i2c_stop;
      chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
   endtask

   task automatic rd_xact(input int n, input bit rstart);
      logic ack;
      logic [7:0] d;
      if (!rstart) i2c_start;
      wr_byte({DEV, 1'b1}, ack);
      chk(ack, "R2 read address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         rd_byte(i != n - 1, d);
         chk(d == exp_rd(i), "R6 read data", d, exp_rd(i));
      end
      i2c_stop;
      chk(sda_oe == 1'b0, "R8 released after read", sda_oe, 0);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic ack, s;
      int n;
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < NW; i++) exp_r[i] = dflt(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset values
      check_regs("R1 reset value");
      chk(sda_oe == 1'b0, "R8 idle released", sda_oe, 0);

      // R3/R4: headers ignored, data from register 0
      wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33;
      wr_xact(DEV, 3, 8'hAA, 8'h55);
      check_regs("R3 R4 sequential write");
      rd_xact(6, 1'b0);

      // R2 wrong address ignored
      wb[0] = 8'hDE; wb[1] = 8'hAD;
      wr_xact(7'h2A, 2, 8'h00, 8'h00);
      check_regs("R2 mismatch no write");

      // R5 write past end, R6 full read-back incl. identification bytes
      for (int i = 0; i < 14; i++) wb[i] = 8'(8'hA0 + i);
      wr_xact(DEV, 14, 8'h01, 8'h02);
      check_regs("R5 write past end");
      rd_xact(15, 1'b0);

      // R7 STOP in mid byte
      i2c_start;
      wr_byte({DEV, 1'b0}, ack);
      wr_byte(8'h00, ack); wr_byte(8'h00, ack);
      wr_byte(8'h5C, ack); exp_r[0] = 8'h5C;
      for (int i = 0; i < 4; i++) bit_x(1'b0, s);
      i2c_stop;
      check_regs("R7 stop mid byte");

      // R7 repeated START mid byte, then read
      i2c_start;
      wr_byte({DEV, 1'b0}, ack);
      wr_byte(8'h00, ack); wr_byte(8'h00, ack);
      wr_byte(8'h3E, ack); exp_r[0] = 8'h3E;
      wr_byte(8'h4F, ack); exp_r[1] = 8'h4F;
      for (int i = 0; i < 3; i++) bit_x(1'b1, s);
      i2c_start;
      rd_xact(4, 1'b1);
      check_regs("R7 repeated start");

      // random mix
      for (int k = 0; k < 24; k++) begin
         if ($urandom_range(0, 2) != 0) begin
            n = $urandom_range(0, 14);
            for (int i = 0; i < 16; i++) wb[i] = 8'($urandom);
            wr_xact(($urandom_range(0, 5) == 0) ? 7'h68 : DEV, n, 8'($urandom), 8'($urandom));
            check_regs("R4 random write");
         end else begin
            rd_xact($urandom_range(1, 14), 1'b0);
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule